// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers a small set of asynchronous event lines into a single level interrupt request for a host processor. Each line first passes through a two-stage synchroniser. A rising edge on a line whose enable bit is set is then held in a sticky status register. The request output is raised when that register changes from all-zero to non-zero. It stays raised until every status bit has been cleared again.

No acknowledge register exists. Software clears a status bit by writing its enable bit to zero, and it can set the enable again later to re-arm the line. The status register is readable through the register port. It is also driven onto a parallel output, so the latched bits can be sampled as one digital-input channel per source.

The register port has no wait states. Writes take effect at the clock edge on which `reg_wr_i` is high. Reads return the data combinationally from `reg_addr_i`.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A rising edge on source i, with enable bit i already set, makes status bit i read 1 three clock edges after the source input changes. The first two edges pass through the synchroniser and the third latches the bit. The bit then stays 1 while the enable stays set.
- R2: A source whose enable bit is 0 never sets its status bit, however its input toggles.
- R3: `irq_o` rises on the clock edge after the status register goes from zero to non-zero. It stays high while any status bit remains set, and setting further bits does not disturb it.
- R4: Writing 0 to enable bit i clears status bit i on that same edge, with no other bit affected. `irq_o` falls on the edge after the whole status register reaches zero.
- R5: A source edge that is detected on the same edge as the write that sets its enable bit to 1 is not latched.
- R6: A source edge that is detected on the same edge as the write that clears its enable bit leaves the status bit at 0: the clear wins.
- R7: Reset clears the enable register and the status register and drives `irq_o` low, including when reset is applied during operation.
- R8: The register map is as follows. Offset 0 is the enable register (read/write, bit i maps to source i). Offset 1 is the status register (read-only: writes to it are ignored). Every other offset reads as zero. Data bits at positions NUM_SRC and above always read as zero.
- R9: `din_view_o` always equals the value of the status register.
- R10: A source input that stays high does not set status again when its enable is set again. Only a new rising edge latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | NUM_SRC | Asynchronous event lines |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_SRC | Write data for the enable register |
| reg_rdata_o | output | DATA_W | Read data for the addressed offset |
| irq_o | output | 1 | Level interrupt request |
| din_view_o | output | NUM_SRC | Status register shown as digital inputs |

## Verification
Edge capture and enable writes can act on the same clock edge. The bench raises a source line and then schedules an enable write for the exact edge on which the synchronised edge is detected. It does this once with the enable going from 0 to 1 (R5) and once with it going from 1 to 0 (R6). In both cases the bench requires the status bit to read 0 afterwards, while status bits for other sources that were already latched must be unchanged. The bench also clears bits one at a time while others remain set, to show that `irq_o` waits for the whole register to reach zero.

// File: rtl/irqlatch_pkg.sv
package irqlatch_pkg;
    // Register offsets on the access port.
    localparam int unsigned OFS_ENABLE = 0;
    localparam int unsigned OFS_STATUS = 1;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] rise_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = src_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // One edge detector per source line.
    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign rise_o[g] = sync_q.stable[g] & ~sync_q.prev[g];
    end
endmodule

// File: rtl/irq_latch_regs.sv
module irq_latch_regs #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_i,
    input  logic             en_wr_i,
    input  logic [WIDTH-1:0] en_wdata_i,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] st_o
);
    typedef struct packed {
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] st;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (en_wr_i) begin
            regs_d.en = en_wdata_i;
        end
        // Capture uses the enable that was already in place, so an edge
        // seen on the edge of the enabling write is dropped. The new enable
        // masks the result, so clearing an enable wins over a capture.
        regs_d.st = (regs_q.st | (rise_i & regs_q.en)) & regs_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o = regs_q.en;
    assign st_o = regs_q.st;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] st_i,
    output logic             irq_o
);
    typedef struct packed {
        logic any_prev;
        logic req;
    } req_t;

    req_t req_d, req_q;
    logic any_now;

    assign any_now = |st_i;

    always_comb begin
        req_d          = req_q;
        req_d.any_prev = any_now;
        if (!any_now) begin
            req_d.req = 1'b0;
        end else if (!req_q.any_prev) begin
            req_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign irq_o = req_q.req;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import irqlatch_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o,
    output logic [NUM_SRC-1:0] din_view_o
);
    localparam logic [ADDR_W-1:0] ADDR_EN = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] ADDR_ST = ADDR_W'(OFS_STATUS);

    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] st_w;
    logic               en_wr_w;

    assign en_wr_w = reg_wr_i && (reg_addr_i == ADDR_EN);

    irq_src_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise_w)
    );

    irq_latch_regs #(.WIDTH(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .en_wr_i    (en_wr_w),
        .en_wdata_i (reg_wdata_i),
        .en_o       (en_w),
        .st_o       (st_w)
    );

    irq_req_gen #(.WIDTH(NUM_SRC)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .st_i  (st_w),
        .irq_o (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_EN) begin
            reg_rdata_o[NUM_SRC-1:0] = en_w;
        end else if (reg_addr_i == ADDR_ST) begin
            reg_rdata_o[NUM_SRC-1:0] = st_w;
        end
    end

    assign din_view_o = st_w;
endmodule

// File: rtl/irq_latch_checker.sv
module irq_latch_checker #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] st_q,
    input logic               irq,
    input logic [DATA_W-1:0]  rdata
);
    // R4: a status bit is never set while its enable is clear
    a_r4_status_within_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~en_q) == '0));

    // R2 / R5: a newly set status bit was enabled on the previous cycle
    a_r2_set_needs_prior_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

    // R3: the request follows the first non-zero status
    a_r3_irq_on_first_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|st_q) |=> irq);

    // R3: the request holds while status is non-zero
    a_r3_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (|st_q)) |=> irq);

    // R4: the request drops after status reaches zero
    a_r4_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == '0) |=> !irq);

    // R8: unused upper read bits stay zero
    a_r8_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DATA_W-1:NUM_SRC] == '0));
endmodule

bind edge_irq_ctrl irq_latch_checker #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_irq_latch_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .en_q  (en_w),
    .st_q  (st_w),
    .irq   (irq_o),
    .rdata (reg_rdata_o)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
    localparam int unsigned NUM_SRC = 6;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_i = '0;
    logic [ADDR_W-1:0]  reg_addr_i = '0;
    logic               reg_wr_i = 1'b0;
    logic [NUM_SRC-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0]  reg_rdata_o;
    logic               irq_o;
    logic [NUM_SRC-1:0] din_view_o;

    always #10 clk = ~clk;  // 50 MHz

    edge_irq_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_edge_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o),
        .din_view_o  (din_view_o)
    );

    typedef struct {
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [NUM_SRC-1:0] view;
        logic               irq;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int checks = 0;
    int errors = 0;

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (reg_rdata_o !== e.data) begin
                    errors++;
                    $display("FAIL %s: rdata @%0d = %h, expected %h", e.tag, e.addr, reg_rdata_o, e.data);
                end
                checks++;
                if (irq_o !== e.irq) begin
                    errors++;
                    $display("FAIL %s: irq_o = %b, expected %b", e.tag, irq_o, e.irq);
                end
                checks++;
                if (din_view_o !== e.view) begin
                    errors++;
                    $display("FAIL %s R9: din_view_o = %h, expected %h", e.tag, din_view_o, e.view);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    // Driver: queues what the requirements predict, then lets the monitor compare.
    task automatic chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [NUM_SRC-1:0] v, input logic q, input string tag);
        exp_t e;
        reg_addr_i = a;
        #1;
        e.addr = a; e.data = d; e.view = v; e.irq = q; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R7 reset state
        chk(0, 8'h00, 6'h00, 1'b0, "R7");
        chk(1, 8'h00, 6'h00, 1'b0, "R7");

        // R2 edge on a disabled source is ignored
        src_i = 6'h01;
        tick(5);
        chk(1, 8'h00, 6'h00, 1'b0, "R2");
        src_i = 6'h00;
        tick(3);

        // R8 upper bits of the enable register read zero
        wr(0, 6'h3F);
        chk(0, 8'h3F, 6'h00, 1'b0, "R8");

        // R1 capture after three edges, R3 request one edge later
        src_i = 6'h04;
        tick(3);
        chk(1, 8'h04, 6'h04, 1'b0, "R1");
        tick(1);
        chk(1, 8'h04, 6'h04, 1'b1, "R3");
        src_i = 6'h14;
        tick(4);
        chk(1, 8'h14, 6'h14, 1'b1, "R3");

        // R4 clearing by disabling, request waits for all-zero
        wr(0, 6'h3B);
        chk(1, 8'h10, 6'h10, 1'b1, "R4");
        chk(0, 8'h3B, 6'h10, 1'b1, "R4");
        wr(0, 6'h2B);
        chk(1, 8'h00, 6'h00, 1'b1, "R4");
        tick(1);
        chk(1, 8'h00, 6'h00, 1'b0, "R4");

        // R10 a level held high is not captured on re-enable
        wr(0, 6'h3F);
        tick(4);
        chk(1, 8'h00, 6'h00, 1'b0, "R10");

        // R8 status is read-only, unused offsets read zero
        wr(1, 6'h3F);
        chk(1, 8'h00, 6'h00, 1'b0, "R8");
        chk(0, 8'h3F, 6'h00, 1'b0, "R8");
        chk(2, 8'h00, 6'h00, 1'b0, "R8");
        chk(3, 8'h00, 6'h00, 1'b0, "R8");

        // R5 edge detected on the same edge as the enabling write
        src_i = 6'h00;
        tick(3);
        wr(0, 6'h00);
        src_i = 6'h01;
        tick(2);
        wr(0, 6'h3F);
        tick(3);
        chk(1, 8'h00, 6'h00, 1'b0, "R5");
        src_i = 6'h03;
        tick(4);
        chk(1, 8'h02, 6'h02, 1'b1, "R1");

        // R6 edge detected on the same edge as the disabling write
        src_i = 6'h0B;
        tick(2);
        wr(0, 6'h37);
        tick(3);
        chk(1, 8'h02, 6'h02, 1'b1, "R6");
        chk(0, 8'h37, 6'h02, 1'b1, "R6");

        // R7 reset during operation
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk(0, 8'h00, 6'h00, 1'b0, "R7");
        chk(1, 8'h00, 6'h00, 1'b0, "R7");

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule